// File: doc/BRIEF.md
# Per-Tile Refresh Countdown Sequencer

This block decides when each tile of a dynamic-memory cache bank must be refreshed. A tile is a run of contiguous lines in one way. Every tile has its own small down-counter, so a leaky tile can be refreshed often while a healthy one is refreshed rarely. A programmable divider turns the fast clock into a coarse time step. On every step, one shared sequencer visits the tile counters in ascending index order. For each tile it decrements the counter, stopping at zero. If the result is zero, it raises a tile refresh request and reloads that counter from the retention profile store.

The profile store is a small synchronous-read memory. It is written through a simple port before a start pulse. The values it holds are assumed to be already corrected for temperature and guardband by other blocks. The start pulse copies every profile entry into its tile counter, one tile after another. Only after that do steps begin. Line-level refresh scheduling sits downstream and accepts tile requests through a valid/ready handshake.

Top module: `tile_refresh_sequencer`

## Requirements
- R1: While `run_en` is high and the block is initialised, a step is produced every `div_period` clock cycles. A `div_period` of 0 or 1 gives a step on every cycle.
- R2: A `start` pulse clears `overrun` and drops any pending request. It then loads each tile counter with its profile entry, in index order, before any step is taken.
- R3: On each step, tiles are visited in ascending index order 0 to NUM_TILES-1. Each counter is decremented by one and held at zero rather than wrapping.
- R4: When a decremented counter is zero, the block raises one request with `req_tile` equal to that tile index. On acceptance, it reloads the counter with the tile's current profile entry. Only then does it move to the next tile.
- R5: A tile whose profile entry is 0 is requested on every step.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` stays high, `req_tile` stays unchanged and the sweep does not advance.
- R7: A step that arrives while a sweep is running, or while earlier steps are still waiting, is queued rather than lost. Every queued step later gets its own full sweep. Such a step also sets `overrun`, which stays set until the next `start`.
- R8: With CNT_W = 1 and profile entries of 1, every tile is requested on every step, as in uniform refresh.
- R9: After reset, `req_valid` and `overrun` are low and the block stays idle until `start`.
- R10: While `run_en` is low, no new steps are produced. Steps already queued are still swept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: load all counters from the profile store and begin operation |
| run_en | input | 1 | Enables the step divider |
| div_period | input | DIV_W | Step period in clock cycles |
| prof_we | input | 1 | Profile store write enable |
| prof_addr | input | TILE_W | Profile store write address (tile index) |
| prof_data | input | CNT_W | Corrected retention count for that tile |
| req_valid | output | 1 | Tile refresh request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_tile | output | TILE_W | Index of the tile to refresh |
| overrun | output | 1 | Sticky: a step arrived before the previous sweep ended |

## Verification
A wrong counter value, whether from a missed decrement, a wrap below zero or a bad reload, changes the order or the number of tile indices seen at the handshake. The scoreboard catches this at the first mismatching request, which comes at most a few steps after the fault. A dropped or duplicated step adds or removes a whole sweep of requests, so the total count is off at the end of a run. A sweep that advances during a stall shows up one cycle later as a changed `req_tile` or a vanished `req_valid`.

// File: rtl/tile_refresh_pkg.sv
package tile_refresh_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_INIT_RD = 3'd1,
    S_INIT_WR = 3'd2,
    S_WAIT    = 3'd3,
    S_RD      = 3'd4,
    S_EVAL    = 3'd5,
    S_REQ     = 3'd6
  } seq_state_t;
endpackage

// File: rtl/step_divider.sv
module step_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] period,
  output logic             step
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      step <= 1'b0;
    end else if (cnt_next >= {1'b0, period}) begin
      cnt  <= '0;
      step <= 1'b1;
    end else begin
      cnt  <= cnt_next[DIV_W-1:0];
      step <= 1'b0;
    end
  end
endmodule

// File: rtl/profile_store.sv
module profile_store #(
  parameter int DEPTH = 16,
  parameter int W     = 6,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tile_sweeper.sv
module tile_sweeper
  import tile_refresh_pkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int CNT_W     = 6,
  parameter int PEND_W    = 4,
  parameter int TILE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run_en,
  input  logic              step,
  input  logic [CNT_W-1:0]  prof_q,
  output logic [TILE_W-1:0] idx,
  output logic              tmr_en,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [TILE_W-1:0] req_tile,
  output logic              overrun
);
  localparam logic [TILE_W-1:0] LAST     = TILE_W'(NUM_TILES - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  seq_state_t        st;
  logic [CNT_W-1:0]  cnt_mem [NUM_TILES];
  logic [PEND_W-1:0] pend;
  logic [CNT_W-1:0]  cur, dec, cnt_wd;
  logic              cnt_we, take;

  always_comb begin
    cur = cnt_mem[idx];
    dec = (cur == '0) ? '0 : cur - CNT_W'(1);
  end

  assign take   = (st == S_WAIT) && (pend != '0);
  assign tmr_en = run_en && (st == S_WAIT || st == S_RD || st == S_EVAL || st == S_REQ);

  always_comb begin
    cnt_we = 1'b0;
    cnt_wd = prof_q;
    if (!start) begin
      case (st)
        S_INIT_WR: cnt_we = 1'b1;
        S_EVAL: if (dec != '0) begin
          cnt_we = 1'b1;
          cnt_wd = dec;
        end
        S_REQ: cnt_we = req_ready;
        default: cnt_we = 1'b0;
      endcase
    end
  end

  // single write port per cycle: one shared decrementer over a RAM-like array
  always_ff @(posedge clk) begin
    if (cnt_we) cnt_mem[idx] <= cnt_wd;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      pend <= '0;
    end else if (step && !take) begin
      if (pend != PEND_MAX) pend <= pend + PEND_W'(1);
    end else if (!step && take) begin
      pend <= pend - PEND_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      req_valid <= 1'b0;
      req_tile  <= '0;
      overrun   <= 1'b0;
    end else if (start) begin
      st        <= S_INIT_RD;
      idx       <= '0;
      req_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      case (st)
        S_IDLE:    st <= S_IDLE;
        S_INIT_RD: st <= S_INIT_WR;
        S_INIT_WR: begin
          if (idx == LAST) st <= S_WAIT;
          else begin
            idx <= idx + TILE_W'(1);
            st  <= S_INIT_RD;
          end
        end
        S_WAIT: begin
          if (pend != '0) begin
            idx <= '0;
            st  <= S_RD;
          end
        end
        S_RD: st <= S_EVAL;
        S_EVAL: begin
          if (dec == '0) begin
            req_valid <= 1'b1;
            req_tile  <= idx;
            st        <= S_REQ;
          end else if (idx == LAST) begin
            st <= S_WAIT;
          end else begin
            idx <= idx + TILE_W'(1);
            st  <= S_RD;
          end
        end
        S_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            if (idx == LAST) st <= S_WAIT;
            else begin
              idx <= idx + TILE_W'(1);
              st  <= S_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (step && (st != S_WAIT || pend != '0)) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/tile_refresh_sequencer.sv
module tile_refresh_sequencer #(
  parameter int NUM_TILES = 16,
  parameter int CNT_W     = 6,
  parameter int DIV_W     = 16,
  parameter int PEND_W    = 4,
  localparam int TILE_W   = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run_en,
  input  logic [DIV_W-1:0]  div_period,
  input  logic              prof_we,
  input  logic [TILE_W-1:0] prof_addr,
  input  logic [CNT_W-1:0]  prof_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [TILE_W-1:0] req_tile,
  output logic              overrun
);
  logic              step_pulse;
  logic              tmr_en;
  logic [CNT_W-1:0]  prof_q;
  logic [TILE_W-1:0] rd_idx;

  step_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .en     (tmr_en),
    .period (div_period),
    .step   (step_pulse)
  );

  profile_store #(.DEPTH(NUM_TILES), .W(CNT_W), .AW(TILE_W)) u_prof (
    .clk   (clk),
    .we    (prof_we),
    .waddr (prof_addr),
    .wdata (prof_data),
    .raddr (rd_idx),
    .rdata (prof_q)
  );

  tile_sweeper #(
    .NUM_TILES (NUM_TILES),
    .CNT_W     (CNT_W),
    .PEND_W    (PEND_W),
    .TILE_W    (TILE_W)
  ) u_sweep (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .run_en    (run_en),
    .step      (step_pulse),
    .prof_q    (prof_q),
    .idx       (rd_idx),
    .tmr_en    (tmr_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tile  (req_tile),
    .overrun   (overrun)
  );
endmodule

// File: rtl/tile_refresh_checker.sv
module tile_refresh_checker #(
  parameter int NUM_TILES = 16,
  parameter int TILE_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              run_en,
  input logic              step,
  input logic              req_valid,
  input logic              req_ready,
  input logic [TILE_W-1:0] req_tile,
  input logic              overrun
);
  a_r6_hold_request: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !start) |=> (req_valid && $stable(req_tile)));

  a_r4_tile_in_range: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (int'(req_tile) < NUM_TILES));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !start) |=> overrun);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!overrun && !req_valid));

  a_r10_no_step_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !step);

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!req_valid && !overrun));
endmodule

bind tile_refresh_sequencer tile_refresh_checker #(
  .NUM_TILES (NUM_TILES),
  .TILE_W    (TILE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .run_en    (run_en),
  .step      (step_pulse),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_tile  (req_tile),
  .overrun   (overrun)
);

// File: tb/sim_tile_refresh_sequencer.sv
module sim_tile_refresh_sequencer;
  localparam int N  = 16;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, run_en = 1'b0, prof_we = 1'b0, req_ready = 1'b1;
  logic [DW-1:0] div_period = '0;
  logic [TW-1:0] prof_addr = '0;
  logic [CW-1:0] prof_data = '0;
  logic req_valid, overrun;
  logic [TW-1:0] req_tile;

  logic s_start = 1'b0, s_run = 1'b0, s_we = 1'b0;
  logic [DW-1:0] s_period = 16'd20;
  logic [1:0] s_addr = '0;
  logic [0:0] s_data = 1'b1;
  logic s_valid, s_overrun;
  logic [1:0] s_tile;

  tile_refresh_sequencer #(.NUM_TILES(N), .CNT_W(CW), .DIV_W(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .run_en(run_en), .div_period(div_period),
    .prof_we(prof_we), .prof_addr(prof_addr), .prof_data(prof_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_tile(req_tile), .overrun(overrun));

  tile_refresh_sequencer #(.NUM_TILES(4), .CNT_W(1), .DIV_W(DW)) u1 (
    .clk(clk), .rst(rst), .start(s_start), .run_en(s_run), .div_period(s_period),
    .prof_we(s_we), .prof_addr(s_addr), .prof_data(s_data),
    .req_valid(s_valid), .req_ready(1'b1), .req_tile(s_tile), .overrun(s_overrun));

  int checks = 0, fails = 0, seen = 0, s_seen = 0, lfsr = 32'h1ace;
  int q[$];
  int rl[N];
  int mc[N];
  bit bp_mode = 1'b0, stall_prev = 1'b0, done = 1'b0;
  logic [TW-1:0] stall_tile;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // ready driver: pseudo-random backpressure when enabled
  always @(posedge clk) begin
    #1;
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
    req_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // monitor: scoreboard pop and stall stability check
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev) chk(req_valid && req_tile == stall_tile, "R6 held request", int'(req_tile), int'(stall_tile));
      stall_prev = req_valid && !req_ready;
      stall_tile = req_tile;
      if (req_valid && req_ready) begin
        seen++;
        if (q.size() == 0) chk(1'b0, "R4 unexpected request", int'(req_tile), -1);
        else begin
          int e;
          e = q.pop_front();
          chk(int'(req_tile) == e, "R3 R4 tile order", int'(req_tile), e);
        end
      end
      if (s_valid) begin
        chk(int'(s_tile) == s_seen % 4, "R8 one-bit tile order", int'(s_tile), s_seen % 4);
        s_seen++;
      end
    end
  end

  task automatic load_profile();
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      prof_we = 1'b1; prof_addr = TW'(i); prof_data = CW'(rl[i]);
    end
    @(posedge clk); #1;
    prof_we = 1'b0;
  endtask

  task automatic do_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (2 * N + 10) @(posedge clk);
    for (int i = 0; i < N; i++) mc[i] = rl[i];
  endtask

  task automatic predict(input int k);
    for (int s = 0; s < k; s++)
      for (int i = 0; i < N; i++) begin
        mc[i] = (mc[i] == 0) ? 0 : mc[i] - 1;
        if (mc[i] == 0) begin
          q.push_back(i);
          mc[i] = rl[i];
        end
      end
  endtask

  task automatic run_window(input int period, input int k, input int drain);
    div_period = DW'(period);
    @(posedge clk); #1 run_en = 1'b1;
    repeat (k * period + period / 2) @(posedge clk);
    #1 run_en = 1'b0;
    repeat (drain) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base, exp_n;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_valid == 1'b0, "R9 reset valid", int'(req_valid), 0);
    chk(overrun == 1'b0, "R9 reset overrun", int'(overrun), 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk(req_valid == 1'b0, "R9 idle before start", int'(req_valid), 0);

    // R2 R3 R4 R5: mixed profile, zero entries, maximum entry, backpressure
    for (int i = 0; i < N; i++) rl[i] = (i * 3) % 7;
    rl[15] = 63;
    load_profile();
    do_start();
    base = seen;
    predict(8);
    exp_n = q.size();
    bp_mode = 1'b1;
    run_window(200, 8, 400);
    bp_mode = 1'b0;
    @(negedge clk);
    chk(q.size() == 0, "R3 all predicted requests seen", q.size(), 0);
    chk(seen - base == exp_n, "R4 request count", seen - base, exp_n);
    chk(overrun == 1'b0, "R7 no overrun with slow steps", int'(overrun), 0);

    // R1: step period check through request count
    for (int i = 0; i < N; i++) rl[i] = 1;
    load_profile();
    do_start();
    base = seen;
    predict(5);
    run_window(60, 5, 200);
    @(negedge clk);
    chk(seen - base == 80, "R1 five steps of period 60", seen - base, 80);
    chk(q.size() == 0, "R1 queue drained", q.size(), 0);

    // R10: no steps while run_en is low
    base = seen;
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk(seen == base, "R10 quiet with run_en low", seen - base, 0);

    // R7 R5: steps faster than sweeps, all-zero profile
    for (int i = 0; i < N; i++) rl[i] = 0;
    load_profile();
    do_start();
    base = seen;
    predict(6);
    bp_mode = 1'b1;
    run_window(10, 6, 1500);
    bp_mode = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun raised", int'(overrun), 1);
    chk(seen - base == 96, "R7 R5 no step dropped", seen - base, 96);
    chk(q.size() == 0, "R5 queue drained", q.size(), 0);
    do_start();
    @(negedge clk);
    chk(overrun == 1'b0, "R2 start clears overrun", int'(overrun), 0);

    // R8: one-bit counters behave as uniform refresh
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 s_we = 1'b1; s_addr = 2'(i); s_data = 1'b1;
    end
    @(posedge clk); #1 s_we = 1'b0;
    @(posedge clk); #1 s_start = 1'b1;
    @(posedge clk); #1 s_start = 1'b0;
    repeat (20) @(posedge clk);
    #1 s_run = 1'b1;
    repeat (70) @(posedge clk);
    #1 s_run = 1'b0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(s_seen == 12, "R8 every tile every step", s_seen, 12);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule